// File: doc/BRIEF.md
# Multi-Rail Power-Up/Down Sequencer

This block sequences the enables of four supply rails: a boost regulator that charges a reserve capacitor rail, an intermediate step-down rail fed from it, a peripheral linear rail, and a core rail. It also drives a switch that moves the core supply onto the reserve rail while the system powers down. Its inputs are digital comparator results that already carry hysteresis. They report battery presence, the ignition key, both reserve-rail thresholds, the intermediate and peripheral rails, and whether the peripheral rail exceeds the core rail by too much. A key-hold bit from the serial register and a core-voltage mode bit complete the inputs.

Every input passes through a two-flop synchroniser and a four-cycle glitch filter. A six-state machine (off, boost, intermediate, peripheral, run, shutdown) then decodes the filtered flags, and all five outputs come from registers. The mode bit picks between two orders. In the higher core-voltage modes the core rail starts with the intermediate rail. In the lowest mode the core rail waits for the peripheral rail, and the peripheral-over-core margin is enforced.

Top module: `pwrseq_top`

## Requirements
- R1: `boost_en_o` is high only while battery-good is set and at least one of key-good or key-latch is set; with battery-good set and neither key source set, every output stays low.
- R2: `sat_en_o` rises only after the reserve-high flag is seen while the boost rail is on. With `low_core_i`=0, `core_en_o` rises on the same edge as `sat_en_o`. With `low_core_i`=1 it does not.
- R3: `peri_en_o` rises once intermediate-good is set while the intermediate rail is enabled, falls when intermediate-good clears, and is never high while `sat_en_o` is low.
- R4: With `low_core_i`=1, `core_en_o` is high only while peripheral-good is set, following it on the way up and on the way down, once the peripheral stage has been reached.
- R5: When the key request is lost after the intermediate rail has started, `boost_en_o` falls, `core_src_resv_o` rises, and the intermediate, peripheral and core enables keep their values.
- R6: In shutdown, clearing the reserve-low flag (reserve above its off threshold) drives all five outputs low and returns the machine to off.
- R7: With `low_core_i`=1, a set difference flag forces `peri_en_o` low and clearing it restores `peri_en_o`; with `low_core_i`=0 the difference flag has no effect on any output.
- R8: An input change reaches the outputs on the 7th rising edge after it is applied (2 synchroniser stages, 4 filter cycles, 1 output register). A pulse that lasts fewer than 4 cycles at the synchroniser output is ignored.
- R9: While `rst_n` is low at a rising edge, all outputs are low. Whenever the machine is off, all outputs are low.
- R10: The key-latch bit alone keeps the boost rail running without key-good. Clearing it with key-good also low starts shutdown. Setting it again from shutdown restarts the full sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Synchronous active-low reset |
| batt_good_i | input | 1 | Battery line above its good threshold |
| key_good_i | input | 1 | Ignition key line above its threshold |
| key_latch_i | input | 1 | Key-hold bit from the serial register |
| resv_hi_i | input | 1 | Reserve rail above its start threshold |
| resv_lo_i | input | 1 | Reserve rail above its off threshold |
| sat_good_i | input | 1 | Intermediate rail good |
| peri_good_i | input | 1 | Peripheral rail above the core-enable threshold |
| diff_trip_i | input | 1 | Peripheral minus core above the allowed margin |
| low_core_i | input | 1 | 1 = lowest core-voltage mode |
| boost_en_o | output | 1 | Boost regulator enable |
| sat_en_o | output | 1 | Intermediate regulator enable |
| peri_en_o | output | 1 | Peripheral regulator enable |
| core_en_o | output | 1 | Core regulator enable |
| core_src_resv_o | output | 1 | Core supply taken from the reserve rail |

## Verification
A flag change applied between edges shows on an output at the 7th following rising edge. Where that change moves the machine through several stages, each further stage adds one edge. The bench measures the 7-edge latency once, sampling after the 6th edge and after the 7th. For every other stimulus it waits 16 edges and samples on a falling edge, which covers the longest chain of four stage steps. The glitch case holds a key source away for 3 cycles and then checks that no output moved.

// File: rtl/pwrseq_pkg.sv
// Package: shared state type, flag positions and the enable bundle of the
// rail sequencer. Assumes flags are packed in the order given by F_*.
package pwrseq_pkg;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_BOOST_ON,
        ST_SAT_ON,
        ST_PERI_ON,
        ST_RUN,
        ST_SHUTDOWN
    } seq_state_t;

    localparam int unsigned NUM_FLAGS = 9;

    localparam int unsigned F_BATT    = 0;
    localparam int unsigned F_KEY     = 1;
    localparam int unsigned F_LATCH   = 2;
    localparam int unsigned F_RESV_HI = 3;
    localparam int unsigned F_RESV_LO = 4;
    localparam int unsigned F_SAT     = 5;
    localparam int unsigned F_PERI    = 6;
    localparam int unsigned F_DIFF    = 7;
    localparam int unsigned F_MODE    = 8;

    typedef struct packed {
        logic boost;
        logic sat;
        logic peri;
        logic core;
        logic src;
    } rail_en_t;

endpackage

// File: rtl/pwrseq_flag_filter.sv
// Flag filter: synchronises one asynchronous flag through SYNC_STAGES flops
// and lets the filtered value follow only after the synchronised value has
// differed from it for FILT_LEN consecutive cycles. Assumes SYNC_STAGES >= 2.
module pwrseq_flag_filter #(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned FILT_LEN    = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic flt_o
);

    localparam int unsigned CNT_W = (FILT_LEN > 1) ? $clog2(FILT_LEN) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FILT_LEN - 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [CNT_W-1:0]       cnt_q;
    logic                   flt_q;
    logic                   sync_w;

    assign sync_w = sync_q[SYNC_STAGES-1];

    // Shift the raw flag through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i};
        end
    end

    // Count cycles of disagreement and adopt the new value after FILT_LEN.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            flt_q <= 1'b0;
        end else if (sync_w == flt_q) begin
            cnt_q <= '0;
        end else if (cnt_q == CNT_LAST) begin
            cnt_q <= '0;
            flt_q <= sync_w;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assign flt_o = flt_q;

endmodule

// File: rtl/pwrseq_flag_bank.sv
// Flag bank: one synchroniser and glitch filter per input flag.
// Assumes all flags are independent and share the same filter length.
module pwrseq_flag_bank #(
    parameter int unsigned NUM         = 9,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned FILT_LEN    = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NUM-1:0] raw_i,
    output logic [NUM-1:0] flt_o
);

    for (genvar g = 0; g < NUM; g++) begin : g_flag
        pwrseq_flag_filter #(
            .SYNC_STAGES(SYNC_STAGES),
            .FILT_LEN   (FILT_LEN)
        ) i_filter (
            .clk  (clk),
            .rst_n(rst_n),
            .raw_i(raw_i[g]),
            .flt_o(flt_o[g])
        );
    end

endmodule

// File: rtl/pwrseq_fsm.sv
// Sequencer state machine: walks off -> boost -> intermediate -> peripheral
// -> run on filtered flags, and goes to shutdown when the key request is lost
// after the intermediate rail has started. Exposes the next state so that the
// enable register can update on the same edge as the state.
module pwrseq_fsm
    import pwrseq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       batt_i,
    input  logic       key_i,
    input  logic       latch_i,
    input  logic       resv_hi_i,
    input  logic       resv_lo_i,
    input  logic       sat_good_i,
    input  logic       peri_good_i,
    input  logic       low_core_i,
    output seq_state_t state_q_o,
    output seq_state_t state_nx_o
);

    seq_state_t state_q;
    seq_state_t state_nx;
    logic       key_req;

    assign key_req = batt_i && (key_i || latch_i);

    // Choose the next sequencing stage from the current one and the flags.
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (key_req) state_nx = ST_BOOST_ON;
            end
            ST_BOOST_ON: begin
                if (!key_req)       state_nx = ST_OFF;
                else if (resv_hi_i) state_nx = ST_SAT_ON;
            end
            ST_SAT_ON: begin
                if (!key_req)        state_nx = ST_SHUTDOWN;
                else if (sat_good_i) state_nx = ST_PERI_ON;
            end
            ST_PERI_ON: begin
                if (!key_req)                        state_nx = ST_SHUTDOWN;
                else if (!low_core_i || peri_good_i) state_nx = ST_RUN;
            end
            ST_RUN: begin
                if (!key_req) state_nx = ST_SHUTDOWN;
            end
            ST_SHUTDOWN: begin
                if (key_req)         state_nx = ST_BOOST_ON;
                else if (!resv_lo_i) state_nx = ST_OFF;
            end
            default: state_nx = ST_OFF;
        endcase
    end

    // Hold the current stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_nx;
        end
    end

    assign state_q_o  = state_q;
    assign state_nx_o = state_nx;

endmodule

// File: rtl/pwrseq_enable_reg.sv
// Enable register: decodes the coming stage and the rail flags into the five
// rail controls and registers them. Assumes the stage input is the next
// state, so enables and state change on the same edge.
module pwrseq_enable_reg
    import pwrseq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  seq_state_t state_nx_i,
    input  logic       resv_lo_i,
    input  logic       sat_good_i,
    input  logic       peri_good_i,
    input  logic       diff_i,
    input  logic       low_core_i,
    output rail_en_t   en_o
);

    rail_en_t en_nx;
    rail_en_t en_q;
    logic     up_sat;
    logic     up_peri;
    logic     peri_allow;

    // Derive the rail controls for the coming stage.
    always_comb begin
        up_sat  = (state_nx_i == ST_SAT_ON) || (state_nx_i == ST_PERI_ON) ||
                  (state_nx_i == ST_RUN) ||
                  ((state_nx_i == ST_SHUTDOWN) && resv_lo_i);
        up_peri = (state_nx_i == ST_PERI_ON) || (state_nx_i == ST_RUN) ||
                  ((state_nx_i == ST_SHUTDOWN) && resv_lo_i);
        peri_allow = !(low_core_i && diff_i);

        en_nx.boost = (state_nx_i == ST_BOOST_ON) || (state_nx_i == ST_SAT_ON) ||
                      (state_nx_i == ST_PERI_ON) || (state_nx_i == ST_RUN);
        en_nx.sat   = up_sat;
        en_nx.peri  = up_peri && sat_good_i && peri_allow;
        en_nx.core  = low_core_i ? (up_peri && peri_good_i) : up_sat;
        en_nx.src   = (state_nx_i == ST_SHUTDOWN);
    end

    // Register the rail controls.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
        end else begin
            en_q <= en_nx;
        end
    end

    assign en_o = en_q;

endmodule

// File: rtl/pwrseq_top.sv
// Rail sequencer top: filters the comparator flags, runs the sequencing
// state machine and drives registered rail enables. Assumes the mode input
// is static in operation; it is filtered like the other flags.
module pwrseq_top
    import pwrseq_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned FILT_LEN    = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic batt_good_i,
    input  logic key_good_i,
    input  logic key_latch_i,
    input  logic resv_hi_i,
    input  logic resv_lo_i,
    input  logic sat_good_i,
    input  logic peri_good_i,
    input  logic diff_trip_i,
    input  logic low_core_i,
    output logic boost_en_o,
    output logic sat_en_o,
    output logic peri_en_o,
    output logic core_en_o,
    output logic core_src_resv_o
);

    logic [NUM_FLAGS-1:0] raw;
    logic [NUM_FLAGS-1:0] flt;
    seq_state_t           state_q;
    seq_state_t           state_nx;
    rail_en_t             en;

    // Pack the flags in package order.
    always_comb begin
        raw            = '0;
        raw[F_BATT]    = batt_good_i;
        raw[F_KEY]     = key_good_i;
        raw[F_LATCH]   = key_latch_i;
        raw[F_RESV_HI] = resv_hi_i;
        raw[F_RESV_LO] = resv_lo_i;
        raw[F_SAT]     = sat_good_i;
        raw[F_PERI]    = peri_good_i;
        raw[F_DIFF]    = diff_trip_i;
        raw[F_MODE]    = low_core_i;
    end

    pwrseq_flag_bank #(
        .NUM        (NUM_FLAGS),
        .SYNC_STAGES(SYNC_STAGES),
        .FILT_LEN   (FILT_LEN)
    ) i_bank (
        .clk  (clk),
        .rst_n(rst_n),
        .raw_i(raw),
        .flt_o(flt)
    );

    pwrseq_fsm i_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .batt_i     (flt[F_BATT]),
        .key_i      (flt[F_KEY]),
        .latch_i    (flt[F_LATCH]),
        .resv_hi_i  (flt[F_RESV_HI]),
        .resv_lo_i  (flt[F_RESV_LO]),
        .sat_good_i (flt[F_SAT]),
        .peri_good_i(flt[F_PERI]),
        .low_core_i (flt[F_MODE]),
        .state_q_o  (state_q),
        .state_nx_o (state_nx)
    );

    pwrseq_enable_reg i_enables (
        .clk        (clk),
        .rst_n      (rst_n),
        .state_nx_i (state_nx),
        .resv_lo_i  (flt[F_RESV_LO]),
        .sat_good_i (flt[F_SAT]),
        .peri_good_i(flt[F_PERI]),
        .diff_i     (flt[F_DIFF]),
        .low_core_i (flt[F_MODE]),
        .en_o       (en)
    );

    assign boost_en_o      = en.boost;
    assign sat_en_o        = en.sat;
    assign peri_en_o       = en.peri;
    assign core_en_o       = en.core;
    assign core_src_resv_o = en.src;

endmodule

// File: rtl/pwrseq_checker.sv
// Checker: relates the registered rail enables to the filtered flags of the
// previous cycle and to the sequencer state. Bound to pwrseq_top below.
module pwrseq_checker
    import pwrseq_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input seq_state_t           state_q,
    input logic [NUM_FLAGS-1:0] flt,
    input logic                 boost_en_o,
    input logic                 sat_en_o,
    input logic                 peri_en_o,
    input logic                 core_en_o,
    input logic                 core_src_resv_o
);

    p_boost_needs_request_r1: assert property (@(posedge clk) disable iff (!rst_n)
        boost_en_o |-> $past(flt[F_BATT] && (flt[F_KEY] || flt[F_LATCH])));

    p_sat_after_reserve_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sat_en_o) |-> $past(flt[F_RESV_HI]));

    p_peri_inside_sat_r3: assert property (@(posedge clk) disable iff (!rst_n)
        peri_en_o |-> sat_en_o);

    p_low_core_needs_peri_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (core_en_o && $past(flt[F_MODE])) |-> $past(flt[F_PERI]));

    p_reserve_source_no_boost_r5: assert property (@(posedge clk) disable iff (!rst_n)
        core_src_resv_o |-> !boost_en_o);

    p_diff_cuts_peri_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(flt[F_MODE] && flt[F_DIFF]) |-> !peri_en_o);

    p_off_is_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OFF) |->
            !(boost_en_o || sat_en_o || peri_en_o || core_en_o || core_src_resv_o));

endmodule

bind pwrseq_top pwrseq_checker i_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .state_q        (state_q),
    .flt            (flt),
    .boost_en_o     (boost_en_o),
    .sat_en_o       (sat_en_o),
    .peri_en_o      (peri_en_o),
    .core_en_o      (core_en_o),
    .core_src_resv_o(core_src_resv_o)
);

// File: tb/test_pwrseq_top.sv
// Bench for the rail sequencer: directed sequences in both modes, then
// seeded random flag vectors compared against a bench stage model.
module test_pwrseq_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [8:0] fl = '0; // 0 batt,1 key,2 latch,3 resv_hi,4 resv_lo,5 sat,6 peri,7 diff,8 low_core
    logic boost_en_o, sat_en_o, peri_en_o, core_en_o, core_src_resv_o;

    int total = 0;
    int bad = 0;
    int mstate = 0;

    always #10 clk = ~clk;

    pwrseq_top i_pwrseq_top (
        .clk            (clk),
        .rst_n          (rst_n),
        .batt_good_i    (fl[0]),
        .key_good_i     (fl[1]),
        .key_latch_i    (fl[2]),
        .resv_hi_i      (fl[3]),
        .resv_lo_i      (fl[4]),
        .sat_good_i     (fl[5]),
        .peri_good_i    (fl[6]),
        .diff_trip_i    (fl[7]),
        .low_core_i     (fl[8]),
        .boost_en_o     (boost_en_o),
        .sat_en_o       (sat_en_o),
        .peri_en_o      (peri_en_o),
        .core_en_o      (core_en_o),
        .core_src_resv_o(core_src_resv_o)
    );

    // Output vector order: boost, sat, peri, core, reserve source.
    function automatic logic [4:0] outs();
        return {boost_en_o, sat_en_o, peri_en_o, core_en_o, core_src_resv_o};
    endfunction

    // Bench stage model: 0 off,1 boost,2 intermediate,3 peripheral,4 run,5 shutdown.
    function automatic int mdl_next(int s, logic [8:0] f);
        logic kr;
        kr = f[0] && (f[1] || f[2]);
        case (s)
            0: return kr ? 1 : 0;
            1: return !kr ? 0 : (f[3] ? 2 : 1);
            2: return !kr ? 5 : (f[5] ? 3 : 2);
            3: return !kr ? 5 : ((!f[8] || f[6]) ? 4 : 3);
            4: return !kr ? 5 : 4;
            default: return kr ? 1 : (!f[4] ? 0 : 5);
        endcase
    endfunction

    function automatic logic [4:0] mdl_out(int s, logic [8:0] f);
        logic b, sat, up, p, c;
        b   = (s >= 1) && (s <= 4);
        sat = (s >= 2 && s <= 4) || (s == 5 && f[4]);
        up  = (s == 3 || s == 4) || (s == 5 && f[4]);
        p   = up && f[5] && !(f[8] && f[7]);
        c   = f[8] ? (up && f[6]) : sat;
        return {b, sat, p, c, (s == 5)};
    endfunction

    task automatic chk(input string tag, input logic [4:0] exp);
        total++;
        if (outs() !== exp) begin
            bad++;
            $display("FAIL %s: got %b expected %b", tag, outs(), exp);
        end
    endtask

    task automatic settle();
        repeat (16) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic step(input logic [8:0] v, input string tag, input logic [4:0] exp);
        fl = v;
        settle();
        chk(tag, exp);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [8:0] v;
        int unsigned seed;
        seed = 32'd2718;
        void'($urandom(seed));

        // R9: reset with flags asserted keeps every output low.
        fl = 9'b0_0111_1111;
        repeat (5) @(posedge clk);
        @(negedge clk);
        chk("R9 reset", 5'b00000);
        fl = '0;
        rst_n = 1'b1;
        settle();
        chk("R9 off after reset", 5'b00000);

        // Higher core-voltage mode.
        step(9'b0_0000_0001, "R1 battery without key", 5'b00000);

        // R8: exact latency of the key request.
        fl = 9'b0_0000_0011;
        repeat (6) @(posedge clk);
        @(negedge clk);
        chk("R8 not yet after 6 edges", 5'b00000);
        @(posedge clk);
        @(negedge clk);
        chk("R8 boost after 7 edges", 5'b10000);

        step(9'b0_0001_1011, "R2 intermediate and core together", 5'b11010);
        step(9'b0_0011_1011, "R3 peripheral after intermediate good", 5'b11110);
        step(9'b0_1011_1011, "R7 difference ignored in high mode", 5'b11110);
        step(9'b0_0001_1011, "R3 peripheral off on intermediate loss", 5'b11010);
        step(9'b0_0011_1011, "R3 peripheral back", 5'b11110);
        step(9'b0_0011_1001, "R5 key loss to reserve source", 5'b01111);
        step(9'b0_0010_0001, "R6 reserve low ends shutdown", 5'b00000);

        // Lowest core-voltage mode.
        step(9'b1_0000_0000, "R9 off in low mode", 5'b00000);
        step(9'b1_0000_0101, "R10 latch alone starts boost", 5'b10000);
        step(9'b1_0001_1101, "R2 core waits in low mode", 5'b11000);
        step(9'b1_0011_1101, "R4 core waits for peripheral good", 5'b11100);
        step(9'b1_0111_1101, "R4 core on with peripheral good", 5'b11110);
        step(9'b1_1111_1101, "R7 difference cuts peripheral", 5'b11010);
        step(9'b1_0111_1101, "R7 difference cleared", 5'b11110);
        step(9'b1_0011_1101, "R4 core off on peripheral loss", 5'b11100);
        step(9'b1_0111_1101, "R4 core back", 5'b11110);

        // R8: latch away for 3 cycles with key low is ignored.
        fl[2] = 1'b0;
        repeat (3) @(negedge clk);
        fl[2] = 1'b1;
        settle();
        chk("R8 short glitch ignored", 5'b11110);

        step(9'b1_0111_1001, "R10 latch clear starts shutdown", 5'b01111);
        step(9'b1_0111_1101, "R10 latch restarts sequence", 5'b11110);

        // Random phase against the bench model.
        fl = '0;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        mstate = 0;
        for (int n = 0; n < 160; n++) begin
            for (int b = 0; b < 7; b++) v[b] = ($urandom_range(0, 3) != 0);
            v[7] = ($urandom_range(0, 3) == 0);
            v[8] = (n >= 80);
            fl = v;
            for (int k = 0; k < 6; k++) mstate = mdl_next(mstate, v);
            settle();
            chk("R2 random sequence", mdl_out(mstate, v));
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule